// File: doc/BRIEF.md
# SMBus Host Status Register

This block holds the eight status flags of an SMBus host controller. The transaction engine reports events to it as one-cycle strobes: a byte moved, an alert seen, a transfer killed, a collision, a device error, a command completed. Each strobe latches its flag. Software reads the flags through a simple register port at one address and clears each flag by writing a 1 to its position.

One position does not follow that pattern. It is a semaphore that software threads use to claim the controller. A read of that position returns its current value and then leaves it at 1. Writing a 1 to it releases the claim. The lowest bit mirrors the engine's busy level. The alert flag has its own reset, taken from the resume well, so a reset of the main well does not erase a pending alert. A registered interrupt level is the OR of the event flags that raise interrupts.

The read data always shows the current register value, and the bus fabric selects it.

Top module: `smb_host_status`

## Requirements
- R1: After reset with both resets asserted, the read data is 8'h00 and irq_o is 0.
- R2: A write to REG_OFFSET clears each of bits 7, 5, 4, 3, 2 and 1 whose write data bit is 1. A 0 in the write data leaves that bit unchanged, and a write to any other address has no effect.
- R3: When a hardware set and a write-1 clear reach the same bit in the same cycle, the bit ends up 1.
- R4: Event strobes set their bits on the next clock edge. byte_done_i sets bit 7, kill_done_i sets bit 4 and collision_i sets bit 3. Any of illegal_cmd_i, unclaimed_i or timeout_i sets bit 2.
- R5: Bit 6 is 0 after rst_ni. A read at REG_OFFSET returns the current value, and the bit is 1 from the next cycle on. A write with data bit 6 = 1 makes it 0, and this takes priority over a read in the same cycle. A write with data bit 6 = 0 has no effect on it.
- R6: Bit 5 sets while alert_i is 1 and alert_is_gpio_i is 0. It never sets while alert_is_gpio_i is 1.
- R7: Bit 5 is cleared by rsm_rst_ni low and is not affected by rst_ni. All other stored bits are reset by rst_ni.
- R8: irq_o equals the OR of bits 5 to 1 as they were one clock earlier. It is 0 once software has cleared those bits.
- R9: Bit 0 shows busy_i in the same cycle, and writes do not change it.
- R10: cmd_done_i sets bit 1 only when intr_en_i is 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Main-well asynchronous reset, active low |
| rsm_rst_ni | input | 1 | Resume-well asynchronous reset, active low (alert flag) |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data (1 = clear) |
| rd_en_i | input | 1 | Read strobe (drives the semaphore side effect) |
| rdata_o | output | 8 | Current register value |
| byte_done_i | input | 1 | Block byte received or sent |
| alert_i | input | 1 | Alert pin asserted |
| alert_is_gpio_i | input | 1 | Alert pin assigned to general-purpose I/O |
| kill_done_i | input | 1 | Transaction terminated by kill |
| collision_i | input | 1 | Bus collision |
| illegal_cmd_i | input | 1 | Illegal command field |
| unclaimed_i | input | 1 | Host cycle unclaimed |
| timeout_i | input | 1 | Device timeout |
| cmd_done_i | input | 1 | Command completed successfully |
| intr_en_i | input | 1 | Completion interrupt enable |
| busy_i | input | 1 | Command executing |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench forces a set and a write-1 clear onto the same bit in one cycle. A design where the clear wins would lose that event and end up 0. It reads the semaphore twice in a row and also combines a read with a release write. A design that applies the read side effect too early, or lets the read beat the release, returns the wrong value. It pulses each reset alone to show that the alert flag survives the main reset but not the resume reset. It checks that irq_o trails the flags by exactly one cycle, which catches an output that is combinational or delayed too long. It also checks that the completion flag and the alert flag stay at 0 while their gates are closed.

// File: rtl/smb_stat_pkg.sv
package smb_stat_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned B_BUSY   = 0;
  localparam int unsigned B_DONE   = 1;
  localparam int unsigned B_DEVERR = 2;
  localparam int unsigned B_BUSERR = 3;
  localparam int unsigned B_FAILED = 4;
  localparam int unsigned B_ALERT  = 5;
  localparam int unsigned B_INUSE  = 6;
  localparam int unsigned B_BYTE   = 7;
  localparam logic [STAT_W-1:0] IRQ_MASK = 8'b0011_1110;
  localparam logic [STAT_W-1:0] W1C_MASK = 8'b1011_1110;

  typedef struct packed {
    logic byte_done;
    logic alert;
    logic failed;
    logic bus_err;
    logic dev_err;
    logic done;
  } stat_ev_t;
endpackage

// File: rtl/smb_w1c_bit.sv
module smb_w1c_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/smb_inuse_sem.sv
module smb_inuse_sem (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic rel_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (rel_i)  q_o <= 1'b0;
    else if (rd_i)   q_o <= 1'b1;
  end
endmodule

// File: rtl/smb_irq_gen.sv
module smb_irq_gen #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] stat_i,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(stat_i & MASK);
  end
endmodule

// File: rtl/smb_host_status.sv
module smb_host_status
  import smb_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rsm_rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [STAT_W-1:0] rdata_o,
  input  logic              byte_done_i,
  input  logic              alert_i,
  input  logic              alert_is_gpio_i,
  input  logic              kill_done_i,
  input  logic              collision_i,
  input  logic              illegal_cmd_i,
  input  logic              unclaimed_i,
  input  logic              timeout_i,
  input  logic              cmd_done_i,
  input  logic              intr_en_i,
  input  logic              busy_i,
  output logic              irq_o
);
  logic              sel;
  logic              wr_hit;
  logic              rd_hit;
  stat_ev_t          ev;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] stat_q;
  logic              unused_bits;

  assign sel    = (addr_i == REG_OFFSET);
  assign wr_hit = wr_en_i && sel;
  assign rd_hit = rd_en_i && sel;

  always_comb begin
    ev.byte_done = byte_done_i;
    ev.alert     = alert_i && !alert_is_gpio_i;
    ev.failed    = kill_done_i;
    ev.bus_err   = collision_i;
    ev.dev_err   = illegal_cmd_i || unclaimed_i || timeout_i;
    ev.done      = cmd_done_i && intr_en_i;
  end

  always_comb begin
    set_vec           = '0;
    set_vec[B_BYTE]   = ev.byte_done;
    set_vec[B_ALERT]  = ev.alert;
    set_vec[B_FAILED] = ev.failed;
    set_vec[B_BUSERR] = ev.bus_err;
    set_vec[B_DEVERR] = ev.dev_err;
    set_vec[B_DONE]   = ev.done;
  end

  assign clr_vec = {STAT_W{wr_hit}} & wdata_i & W1C_MASK;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (W1C_MASK[i]) begin : g_w1c
      if (i == B_ALERT) begin : g_rsm
        smb_w1c_bit u_bit (
          .clk_i  (clk_i),
          .rst_ni (rsm_rst_ni),
          .set_i  (set_vec[i]),
          .clr_i  (clr_vec[i]),
          .q_o    (stat_q[i])
        );
      end else begin : g_main
        smb_w1c_bit u_bit (
          .clk_i  (clk_i),
          .rst_ni (rst_ni),
          .set_i  (set_vec[i]),
          .clr_i  (clr_vec[i]),
          .q_o    (stat_q[i])
        );
      end
    end
  end

  smb_inuse_sem u_sem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_hit),
    .rel_i  (wr_hit && wdata_i[B_INUSE]),
    .q_o    (stat_q[B_INUSE])
  );

  assign stat_q[B_BUSY] = busy_i;
  assign unused_bits = ^{set_vec[B_BUSY], set_vec[B_INUSE], clr_vec[B_BUSY], clr_vec[B_INUSE]};

  smb_irq_gen #(
    .W    (STAT_W),
    .MASK (IRQ_MASK)
  ) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stat_i (stat_q),
    .irq_o  (irq_o)
  );

  assign rdata_o = stat_q;
endmodule

// File: rtl/smb_host_status_chk.sv
module smb_host_status_chk
  import smb_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rsm_rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [STAT_W-1:0] wdata_i,
  input logic              rd_en_i,
  input logic [STAT_W-1:0] rdata_o,
  input logic              kill_done_i,
  input logic              collision_i,
  input logic              alert_is_gpio_i,
  input logic              cmd_done_i,
  input logic              intr_en_i,
  input logic              irq_o
);
  logic wr_hit, rd_hit;
  assign wr_hit = wr_en_i && (addr_i == REG_OFFSET);
  assign rd_hit = rd_en_i && (addr_i == REG_OFFSET);

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni || !rsm_rst_ni)
    wr_hit && wdata_i[B_FAILED] && !kill_done_i |=> !rdata_o[B_FAILED]); // R2
  AST_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni || !rsm_rst_ni)
    wr_en_i && !wdata_i[B_BUSERR] && rdata_o[B_BUSERR] |=> rdata_o[B_BUSERR]); // R2
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni || !rsm_rst_ni)
    collision_i |=> rdata_o[B_BUSERR]); // R3
  AST_SEM_READ: assert property (@(posedge clk_i) disable iff (!rst_ni || !rsm_rst_ni)
    rd_hit && !(wr_hit && wdata_i[B_INUSE]) |=> rdata_o[B_INUSE]); // R5
  AST_SEM_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni || !rsm_rst_ni)
    wr_hit && wdata_i[B_INUSE] |=> !rdata_o[B_INUSE]); // R5
  AST_GPIO_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni || !rsm_rst_ni)
    alert_is_gpio_i && !rdata_o[B_ALERT] |=> !rdata_o[B_ALERT]); // R6
  AST_IRQ_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni || !rsm_rst_ni)
    rst_ni |=> irq_o == $past(|(rdata_o & IRQ_MASK))); // R8
  AST_DONE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni || !rsm_rst_ni)
    cmd_done_i && !intr_en_i && !rdata_o[B_DONE] && !(wr_hit && 1'b0) |=> !rdata_o[B_DONE]); // R10
endmodule

bind smb_host_status smb_host_status_chk #(
  .ADDR_W     (ADDR_W),
  .REG_OFFSET (REG_OFFSET)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .rsm_rst_ni      (rsm_rst_ni),
  .addr_i          (addr_i),
  .wr_en_i         (wr_en_i),
  .wdata_i         (wdata_i),
  .rd_en_i         (rd_en_i),
  .rdata_o         (rdata_o),
  .kill_done_i     (kill_done_i),
  .collision_i     (collision_i),
  .alert_is_gpio_i (alert_is_gpio_i),
  .cmd_done_i      (cmd_done_i),
  .intr_en_i       (intr_en_i),
  .irq_o           (irq_o)
);

// File: tb/sim_smb_host_status.sv
module sim_smb_host_status;
  logic       clk = 1'b0;
  logic       rst_n, rsm_rst_n;
  logic [7:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       byte_done, alert, alert_gpio, kill_done, collision;
  logic       ill_cmd, unclaimed, timeout, cmd_done, intr_en, busy;
  logic       irq;
  int         checks = 0;
  int         errors = 0;

  always #10 clk = ~clk;

  smb_host_status u0 (
    .clk_i(clk), .rst_ni(rst_n), .rsm_rst_ni(rsm_rst_n),
    .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en),
    .rdata_o(rdata), .byte_done_i(byte_done), .alert_i(alert),
    .alert_is_gpio_i(alert_gpio), .kill_done_i(kill_done),
    .collision_i(collision), .illegal_cmd_i(ill_cmd), .unclaimed_i(unclaimed),
    .timeout_i(timeout), .cmd_done_i(cmd_done), .intr_en_i(intr_en),
    .busy_i(busy), .irq_o(irq)
  );

  // {byte,alert,kill,coll,ill,cmd,ien}, wr, wdata, expected
  localparam logic [23:0] VEC [0:12] = '{
    {7'h40, 1'b0, 8'h00, 8'h80},
    {7'h00, 1'b1, 8'h00, 8'h80},
    {7'h10, 1'b0, 8'h00, 8'h90},
    {7'h08, 1'b1, 8'h80, 8'h18},
    {7'h04, 1'b0, 8'h00, 8'h1C},
    {7'h02, 1'b0, 8'h00, 8'h1C},
    {7'h03, 1'b0, 8'h00, 8'h1E},
    {7'h00, 1'b1, 8'hFF, 8'h00},
    {7'h20, 1'b0, 8'h00, 8'h20},
    {7'h20, 1'b1, 8'h20, 8'h20},
    {7'h00, 1'b1, 8'h20, 8'h00},
    {7'h10, 1'b1, 8'h10, 8'h10},
    {7'h00, 1'b1, 8'h10, 8'h00}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; wdata = 0; addr = 0;
    byte_done = 0; alert = 0; kill_done = 0; collision = 0;
    ill_cmd = 0; unclaimed = 0; timeout = 0; cmd_done = 0; intr_en = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    tick();
    idle();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] prev;
    idle(); alert_gpio = 0; busy = 0;
    rst_n = 0; rsm_rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; rsm_rst_n = 1;
    @(negedge clk);
    chk("R1 reset value", rdata, 8'h00);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);

    prev = 8'h00;
    for (int i = 0; i < 13; i++) begin
      {byte_done, alert, kill_done, collision, ill_cmd, cmd_done, intr_en} = VEC[i][23:17];
      wr_en = VEC[i][16]; wdata = VEC[i][15:8]; addr = 0;
      tick();
      idle();
      chk($sformatf("R2 R3 R4 R6 R10 vector %0d", i), rdata, VEC[i][7:0]);
      chk($sformatf("R8 irq vector %0d", i), {7'd0, irq}, {7'd0, |prev[5:1]});
      prev = VEC[i][7:0];
    end
    tick();
    chk("R8 irq drops after clear", {7'd0, irq}, 8'h00);

    // R4 remaining device error sources
    unclaimed = 1; tick(); idle();
    chk("R4 unclaimed", rdata, 8'h04);
    wr(8'h00, 8'h04);
    timeout = 1; tick(); idle();
    chk("R4 timeout", rdata, 8'h04);
    wr(8'h00, 8'h04);
    chk("R2 clear dev err", rdata, 8'h00);

    // R2 other address ignored
    kill_done = 1; tick(); idle();
    wr(8'h01, 8'hFF);
    chk("R2 other address", rdata, 8'h10);
    wr(8'h00, 8'hFF);
    chk("R2 clear failed", rdata, 8'h00);
    tick();

    // R9 busy mirror
    busy = 1; #1;
    chk("R9 busy same cycle", rdata, 8'h01);
    wr(8'h00, 8'h01);
    chk("R9 write ignored", rdata, 8'h01);
    busy = 0; #1;
    chk("R9 busy low", rdata, 8'h00);

    // R5 semaphore
    addr = 0; rd_en = 1; #1;
    chk("R5 first read", rdata, 8'h00);
    tick(); #1;
    chk("R5 second read", rdata, 8'h40);
    tick(); idle();
    chk("R5 stays set", rdata, 8'h40);
    wr(8'h00, 8'h00);
    chk("R5 zero write", rdata, 8'h40);
    wr(8'h00, 8'h40);
    chk("R5 release", rdata, 8'h00);
    rd_en = 1; wr_en = 1; wdata = 8'h40; tick(); idle();
    chk("R5 release beats read", rdata, 8'h00);

    // R6 gpio gating
    alert_gpio = 1; alert = 1; tick(); tick();
    chk("R6 gpio blocks alert", rdata, 8'h00);
    alert_gpio = 0; tick(); idle();
    chk("R6 alert sets", rdata, 8'h20);
    rd_en = 1; tick(); idle();
    chk("R5 set before reset", rdata, 8'h60);

    // R7 reset domains
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R7 alert survives main reset", rdata, 8'h20);
    tick();
    chk("R8 irq from alert", {7'd0, irq}, 8'h01);
    rsm_rst_n = 0; @(negedge clk); rsm_rst_n = 1; @(negedge clk);
    chk("R7 resume reset clears alert", rdata, 8'h00);

    finish_run();
  end
endmodule